// File: doc/BRIEF.md
# Quad-I/O Execute-in-Place Flash Read Controller

This block sits between an on-chip requester and a serial NOR flash wired with four data lines. On each request it selects the flash and sends the quad-I/O fast-read opcode on one line. It then sends the 24-bit start address and a mode byte on all four lines, waits out the dummy clocks and collects the requested number of bytes. It returns each byte with a one-cycle valid strobe and deselects the flash when the count is reached. The serial clock runs at half the system clock.

The mode byte controls continuous-read operation. When the configuration input asks to stay, the controller sends 0xA0. The controller and the flash then both expect the next read to start directly with the address, which saves eight serial clocks per access. When the input asks to leave, the controller sends 0x00 and the next read carries the opcode again. A separate strobe issues an eight-clock sequence with all four lines high. This sequence takes the flash out of continuous-read mode whatever its state, and the controller clears its own flag to match.

Top module: `qspi_xip_reader`

## Requirements
- R1: After reset cs_n is 1, sck is 0, io_oe is 0000, busy is 0, rd_valid is 0 and cont_active is 0. While cs_n is 0, busy is 1.
- R2: A read started while cont_active is 0 first sends opcode 0xEB on io_out[0] over 8 serial clocks, most significant bit first, with io_oe = 0001.
- R3: The address follows over 6 serial clocks, one nibble per clock, bits 23..20 first and bits 3..0 last, with io_oe = 1111.
- R4: The mode byte follows over 2 serial clocks, high nibble first, with io_oe = 1111. Its value is 0xA0 when cfg_keep_cont was 1 at the start strobe, and 0x00 otherwise.
- R5: From the first of the 4 dummy clocks until cs_n rises, io_oe is 0000. io_oe only ever takes the values 0000, 0001 and 1111.
- R6: Each byte is built from two nibbles sampled from io_in on rising sck edges, high nibble first. rd_valid pulses for one cycle per byte while cs_n is still 0. Exactly req_len bytes are returned, from consecutive addresses wrapping at 2^24. A read without the opcode takes 12 + 2*req_len serial clocks.
- R7: A read whose mode byte was 0xA0 sets cont_active during that read. The next read skips the opcode: its first serial clock already carries address bits 23..20.
- R8: A read whose mode byte was 0x00 clears cont_active. The next read sends the opcode again and takes 20 + 2*req_len serial clocks.
- R9: mode_rst_start issues one selection of exactly 8 serial clocks with io_out = 1111 and io_oe = 1111, then clears cont_active. The next read sends the opcode.
- R10: A req_start or mode_rst_start that arrives while busy is 1 is ignored. It starts no further selection and does not alter the data of the read in progress.
- R11: sck is 0 whenever cs_n is 1. While cs_n is 0, sck alternates every system cycle, so one serial clock lasts two system cycles.
- R12: When mode_rst_start and req_start are both 1 in the same idle cycle, only the mode-reset sequence runs and the read request is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| req_start | input | 1 | Start a read; sampled while idle |
| req_addr | input | 24 | Start byte address of the read |
| req_len | input | LEN_W | Number of bytes to read; 0 is treated as 1 |
| cfg_keep_cont | input | 1 | 1 = send mode byte 0xA0, 0 = send 0x00 |
| mode_rst_start | input | 1 | Start the continuous-mode reset sequence |
| busy | output | 1 | Controller is running a sequence |
| rd_data | output | 8 | Received byte |
| rd_valid | output | 1 | rd_data holds a new byte this cycle |
| cont_active | output | 1 | Flash is expected to be in continuous-read mode |
| cs_n | output | 1 | Flash chip select, active low |
| sck | output | 1 | Flash serial clock |
| io_out | output | 4 | Values driven onto the four IO lines |
| io_oe | output | 4 | Per-line output enable |
| io_in | input | 4 | Values read from the four IO lines |

## Verification
Take E0 as the clock edge that samples a start strobe. cs_n falls at E0. Serial rising edge k (counted from 1) occurs at edge E0+2k-1. Let P be 12 in continuous mode and 20 otherwise. Byte b (from 0) shows rd_valid in the cycle after edge E0+2(P+2b+2)-1, and cs_n rises at edge E0+2(P+2*req_len). The bench does not predict those edges one by one. Its flash model logs every IO nibble at each rising sck, and a monitor collects every rd_valid byte at the falling system-clock edge. Once busy drops, the bench compares the logs against values computed from the request, so serial-clock counts, field positions and byte order are checked without depending on the order of processes at any edge.

// File: rtl/qxr_pkg.sv
package qxr_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_CMD,
        ST_ADDR,
        ST_MODE,
        ST_DUMMY,
        ST_DATA,
        ST_MRST,
        ST_GAP
    } qxr_state_e;

    localparam logic [7:0] QIO_READ_OP = 8'hEB;
    localparam logic [7:0] MODE_STAY   = 8'hA0;
    localparam logic [7:0] MODE_LEAVE  = 8'h00;
    localparam logic [3:0] STAY_NIB    = 4'hA;

    localparam int OP_CLKS    = 8;
    localparam int ADDR_CLKS  = 6;
    localparam int MODE_CLKS  = 2;
    localparam int DUMMY_CLKS = 4;
    localparam int MRST_CLKS  = 8;

    typedef struct packed {
        logic [23:0] addr;
        logic [7:0]  mode;
    } qxr_hdr_t;

    function automatic qxr_state_e step_after(qxr_state_e s);
        case (s)
            ST_CMD:   return ST_ADDR;
            ST_ADDR:  return ST_MODE;
            ST_MODE:  return ST_DUMMY;
            ST_DUMMY: return ST_DATA;
            default:  return ST_GAP;
        endcase
    endfunction

    function automatic logic [3:0] addr_nibble(logic [23:0] a, logic [2:0] pos);
        logic [2:0] sel;
        sel = 3'(ADDR_CLKS - 1) - pos;
        return a[sel*4 +: 4];
    endfunction

endpackage

// File: rtl/qxr_seq.sv
module qxr_seq
    import qxr_pkg::*;
#(
    parameter int LEN_W = 8,
    localparam int CNT_W = LEN_W + 1
)(
    input  logic             clk,
    input  logic             rst,
    input  logic             req_start,
    input  logic [23:0]      req_addr,
    input  logic [LEN_W-1:0] req_len,
    input  logic             cfg_keep_cont,
    input  logic             mode_rst_start,
    output qxr_state_e       state,
    output logic [2:0]       pos,
    output qxr_hdr_t         hdr,
    output logic             cs_n,
    output logic             sck,
    output logic             smp,
    output logic             smp_lo,
    output logic             cont,
    output logic             busy
);

    logic [CNT_W-1:0] cnt;
    logic [CNT_W-1:0] last_idx;
    logic [LEN_W-1:0] len_q;
    logic             ph;
    qxr_state_e       nxt;

    always_comb begin
        case (state)
            ST_CMD:   last_idx = CNT_W'(OP_CLKS - 1);
            ST_ADDR:  last_idx = CNT_W'(ADDR_CLKS - 1);
            ST_MODE:  last_idx = CNT_W'(MODE_CLKS - 1);
            ST_DUMMY: last_idx = CNT_W'(DUMMY_CLKS - 1);
            ST_MRST:  last_idx = CNT_W'(MRST_CLKS - 1);
            ST_DATA:  last_idx = {len_q - 1'b1, 1'b1};
            default:  last_idx = '0;
        endcase
    end

    assign nxt    = step_after(state);
    assign pos    = cnt[2:0];
    assign smp    = (state == ST_DATA) && !ph;
    assign smp_lo = cnt[0];
    assign busy   = (state != ST_IDLE);

    always_ff @(posedge clk) begin
        if (rst) begin
            state <= ST_IDLE;
            cnt   <= '0;
            ph    <= 1'b0;
            cs_n  <= 1'b1;
            sck   <= 1'b0;
            cont  <= 1'b0;
            hdr   <= '0;
            len_q <= '0;
        end else begin
            case (state)
                ST_IDLE: begin
                    cnt <= '0;
                    ph  <= 1'b0;
                    if (mode_rst_start) begin
                        state <= ST_MRST;
                        cs_n  <= 1'b0;
                    end else if (req_start) begin
                        hdr.addr <= req_addr;
                        hdr.mode <= cfg_keep_cont ? MODE_STAY : MODE_LEAVE;
                        len_q    <= (req_len == '0) ? LEN_W'(1) : req_len;
                        state    <= cont ? ST_ADDR : ST_CMD;
                        cs_n     <= 1'b0;
                    end
                end
                ST_GAP: begin
                    state <= ST_IDLE;
                end
                default: begin
                    if (!ph) begin
                        ph  <= 1'b1;
                        sck <= 1'b1;
                    end else begin
                        ph  <= 1'b0;
                        sck <= 1'b0;
                        if (cnt == last_idx) begin
                            cnt   <= '0;
                            state <= nxt;
                            if (state == ST_MODE)
                                cont <= (hdr.mode[7:4] == STAY_NIB);
                            if (state == ST_MRST)
                                cont <= 1'b0;
                            if (nxt == ST_GAP)
                                cs_n <= 1'b1;
                        end else begin
                            cnt <= cnt + 1'b1;
                        end
                    end
                end
            endcase
        end
    end

endmodule

// File: rtl/qxr_txmux.sv
module qxr_txmux
    import qxr_pkg::*;
(
    input  qxr_state_e state,
    input  logic [2:0] pos,
    input  qxr_hdr_t   hdr,
    output logic [3:0] io_out,
    output logic [3:0] io_oe
);

    always_comb begin
        io_out = 4'h0;
        io_oe  = 4'h0;
        case (state)
            ST_CMD: begin
                io_out = {3'b000, QIO_READ_OP[3'd7 - pos]};
                io_oe  = 4'b0001;
            end
            ST_ADDR: begin
                io_out = addr_nibble(hdr.addr, pos);
                io_oe  = 4'hF;
            end
            ST_MODE: begin
                io_out = pos[0] ? hdr.mode[3:0] : hdr.mode[7:4];
                io_oe  = 4'hF;
            end
            ST_MRST: begin
                io_out = 4'hF;
                io_oe  = 4'hF;
            end
            default: begin
                io_out = 4'h0;
                io_oe  = 4'h0;
            end
        endcase
    end

endmodule

// File: rtl/qxr_rxpack.sv
module qxr_rxpack (
    input  logic       clk,
    input  logic       rst,
    input  logic       smp,
    input  logic       smp_lo,
    input  logic [3:0] io_in,
    output logic [7:0] rd_data,
    output logic       rd_valid
);

    logic [3:0] hi_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            hi_q     <= '0;
            rd_data  <= '0;
            rd_valid <= 1'b0;
        end else begin
            rd_valid <= 1'b0;
            if (smp) begin
                if (smp_lo) begin
                    rd_data  <= {hi_q, io_in};
                    rd_valid <= 1'b1;
                end else begin
                    hi_q <= io_in;
                end
            end
        end
    end

endmodule

// File: rtl/qspi_xip_reader.sv
module qspi_xip_reader
    import qxr_pkg::*;
#(
    parameter int LEN_W = 8
)(
    input  logic             clk,
    input  logic             rst,
    input  logic             req_start,
    input  logic [23:0]      req_addr,
    input  logic [LEN_W-1:0] req_len,
    input  logic             cfg_keep_cont,
    input  logic             mode_rst_start,
    output logic             busy,
    output logic [7:0]       rd_data,
    output logic             rd_valid,
    output logic             cont_active,
    output logic             cs_n,
    output logic             sck,
    output logic [3:0]       io_out,
    output logic [3:0]       io_oe,
    input  logic [3:0]       io_in
);

    qxr_state_e state;
    logic [2:0] pos;
    qxr_hdr_t   hdr;
    logic       smp;
    logic       smp_lo;

    qxr_seq #(.LEN_W(LEN_W)) i_seq (
        .clk            (clk),
        .rst            (rst),
        .req_start      (req_start),
        .req_addr       (req_addr),
        .req_len        (req_len),
        .cfg_keep_cont  (cfg_keep_cont),
        .mode_rst_start (mode_rst_start),
        .state          (state),
        .pos            (pos),
        .hdr            (hdr),
        .cs_n           (cs_n),
        .sck            (sck),
        .smp            (smp),
        .smp_lo         (smp_lo),
        .cont           (cont_active),
        .busy           (busy)
    );

    qxr_txmux i_txmux (
        .state  (state),
        .pos    (pos),
        .hdr    (hdr),
        .io_out (io_out),
        .io_oe  (io_oe)
    );

    qxr_rxpack i_rxpack (
        .clk      (clk),
        .rst      (rst),
        .smp      (smp),
        .smp_lo   (smp_lo),
        .io_in    (io_in),
        .rd_data  (rd_data),
        .rd_valid (rd_valid)
    );

endmodule

// File: rtl/qxr_checker.sv
module qxr_checker (
    input logic       clk,
    input logic       rst,
    input logic       cs_n,
    input logic       sck,
    input logic [3:0] io_oe,
    input logic       busy,
    input logic       rd_valid,
    input logic       cont_active
);

    assert_quiet_deselected_R11: assert property (@(posedge clk) disable iff (rst)
        cs_n |-> (!sck && io_oe == 4'h0));

    assert_sck_alternates_R11: assert property (@(posedge clk) disable iff (rst)
        (!cs_n && sck) |=> !sck);

    assert_oe_legal_R5: assert property (@(posedge clk) disable iff (rst)
        (io_oe == 4'h0 || io_oe == 4'h1 || io_oe == 4'hF));

    assert_selected_busy_R1: assert property (@(posedge clk) disable iff (rst)
        !cs_n |-> busy);

    assert_valid_single_R6: assert property (@(posedge clk) disable iff (rst)
        rd_valid |=> !rd_valid);

    assert_valid_selected_R6: assert property (@(posedge clk) disable iff (rst)
        rd_valid |-> !cs_n);

    assert_cont_set_in_read_R7: assert property (@(posedge clk) disable iff (rst)
        $rose(cont_active) |-> !cs_n);

endmodule

bind qspi_xip_reader qxr_checker i_chk (.*);

// File: tb/test_qspi_xip_reader.sv
module test_qspi_xip_reader;

    localparam int CLK_PERIOD = 10;
    localparam int LEN_W = 8;

    logic             clk = 1'b0;
    logic             rst = 1'b1;
    logic             req_start = 1'b0;
    logic [23:0]      req_addr = '0;
    logic [LEN_W-1:0] req_len = '0;
    logic             cfg_keep_cont = 1'b0;
    logic             mode_rst_start = 1'b0;
    logic             busy;
    logic [7:0]       rd_data;
    logic             rd_valid;
    logic             cont_active;
    logic             cs_n;
    logic             sck;
    logic [3:0]       io_out;
    logic [3:0]       io_oe;
    logic [3:0]       io_in = 4'h0;

    qspi_xip_reader #(.LEN_W(LEN_W)) i_qspi_xip_reader (.*);

    always #(CLK_PERIOD/2) clk = ~clk;

    int vectors = 0;
    int miscompares = 0;

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        vectors++;
        if (!ok) begin
            miscompares++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic logic [7:0] fbyte(logic [23:0] a);
        return (a[7:0] * 8'd7) ^ a[15:8] ^ {a[19:16], a[23:20]};
    endfunction

    // flash model
    logic [3:0] nib_log [0:127];
    logic [3:0] oe_log  [0:127];
    int  rises = 0;
    int  tr_count = 0;
    bit  flash_cont = 0;
    bit  model_skip = 0;

    always @(negedge cs_n) begin
        rises = 0;
        tr_count++;
        model_skip = flash_cont;
    end

    always @(posedge sck) begin
        if (!cs_n) begin
            if (rises < 128) begin
                nib_log[rises] = io_out;
                oe_log[rises]  = io_oe;
            end
            rises++;
        end
    end

    always @(negedge sck) begin
        int base;
        int k;
        logic [23:0] a;
        logic [7:0]  b;
        if (!cs_n) begin
            base = model_skip ? 0 : 8;
            if (rises >= base + 12) begin
                a = '0;
                for (int i = 0; i < 6; i++) a = {a[19:0], nib_log[base+i]};
                k = rises - base - 12;
                b = fbyte(a + 24'(k / 2));
                io_in = (k % 2 == 0) ? b[7:4] : b[3:0];
            end
        end
    end

    always @(posedge cs_n) begin
        int base;
        bit allf;
        base = model_skip ? 0 : 8;
        allf = 1;
        for (int i = 0; i < 8; i++)
            if (i < rises && (nib_log[i] != 4'hF || oe_log[i] != 4'hF)) allf = 0;
        if (rises == 8 && allf) flash_cont = 0;
        else if (rises >= base + 12) flash_cont = (nib_log[base+6] == 4'hA);
    end

    // byte collector
    logic [7:0] rx_q [0:63];
    int rx_n = 0;
    always @(negedge clk) begin
        if (!rst && rd_valid) begin
            if (rx_n < 64) rx_q[rx_n] = rd_data;
            rx_n++;
        end
    end

    // R11 monitor
    int  r11_viol = 0;
    logic prev_sck = 1'b0;
    logic prev_cs = 1'b1;
    always @(negedge clk) begin
        if (!rst) begin
            if (cs_n && sck) r11_viol++;
            if (!cs_n && !prev_cs && sck == prev_sck) r11_viol++;
        end
        prev_sck = sck;
        prev_cs  = cs_n;
    end

    bit exp_cont = 0;

    task automatic do_read(input logic [23:0] a, input int len, input bit keep, input bit inject);
        int  base;
        int  tr0;
        bit  sk;
        bit  ok;
        logic [7:0]  cmd;
        logic [23:0] ad;
        logic [7:0]  md;
        string rt;
        sk = exp_cont;
        base = sk ? 0 : 8;
        rt = sk ? "R7" : "R8";
        @(negedge clk);
        tr0 = tr_count;
        rx_n = 0;
        req_addr = a;
        req_len = LEN_W'(len);
        cfg_keep_cont = keep;
        req_start = 1'b1;
        @(negedge clk);
        req_start = 1'b0;
        if (inject) begin
            repeat (6) @(negedge clk);
            req_addr = ~a;
            req_start = 1'b1;
            mode_rst_start = 1'b1;
            @(negedge clk);
            req_start = 1'b0;
            mode_rst_start = 1'b0;
        end
        while (busy) @(negedge clk);
        repeat (2) @(negedge clk);

        if (inject) chk(tr_count == tr0 + 1, "R10 one selection", tr_count - tr0, 1);
        chk(rises == base + 12 + 2*len, {rt, " serial clock count"}, rises, base + 12 + 2*len);
        if (!sk) begin
            cmd = '0;
            ok = 1;
            for (int i = 0; i < 8; i++) begin
                cmd = {cmd[6:0], nib_log[i][0]};
                if (oe_log[i] != 4'b0001) ok = 0;
            end
            chk(cmd == 8'hEB, "R2 opcode", cmd, 8'hEB);
            chk(ok, "R2 opcode enables", 0, 1);
        end
        ad = '0;
        ok = 1;
        for (int i = 0; i < 6; i++) begin
            ad = {ad[19:0], nib_log[base+i]};
            if (oe_log[base+i] != 4'hF) ok = 0;
        end
        chk(ad == a, sk ? "R7 address first" : "R3 address", ad, a);
        chk(ok, "R3 address enables", 0, 1);
        md = {nib_log[base+6], nib_log[base+7]};
        chk(md == (keep ? 8'hA0 : 8'h00), "R4 mode byte", md, keep ? 8'hA0 : 8'h00);
        ok = 1;
        for (int i = base + 8; i < rises && i < 128; i++)
            if (oe_log[i] != 4'h0) ok = 0;
        chk(ok, "R5 lines released", 0, 1);
        chk(rx_n == len, "R6 byte count", rx_n, len);
        for (int i = 0; i < len && i < rx_n; i++)
            chk(rx_q[i] == fbyte(a + 24'(i)), "R6 byte value", rx_q[i], fbyte(a + 24'(i)));
        chk(cont_active == keep, keep ? "R7 cont flag" : "R8 cont flag", cont_active, keep);
        exp_cont = keep;
    endtask

    task automatic do_mrst(input bit with_read);
        int tr0;
        bit ok;
        @(negedge clk);
        tr0 = tr_count;
        rx_n = 0;
        mode_rst_start = 1'b1;
        req_start = with_read;
        req_addr = 24'h123456;
        req_len = 8'd2;
        @(negedge clk);
        mode_rst_start = 1'b0;
        req_start = 1'b0;
        while (busy) @(negedge clk);
        repeat (2) @(negedge clk);
        chk(rises == 8, with_read ? "R12 reset wins" : "R9 reset length", rises, 8);
        ok = 1;
        for (int i = 0; i < 8; i++)
            if (nib_log[i] != 4'hF || oe_log[i] != 4'hF) ok = 0;
        chk(ok, "R9 lines high", 0, 1);
        chk(cont_active == 1'b0, "R9 cont cleared", cont_active, 0);
        chk(tr_count == tr0 + 1, with_read ? "R12 single selection" : "R9 single selection", tr_count - tr0, 1);
        chk(rx_n == 0, "R12 no data", rx_n, 0);
        exp_cont = 0;
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        chk(cs_n == 1'b1, "R1 cs_n", cs_n, 1);
        chk(sck == 1'b0, "R1 sck", sck, 0);
        chk(io_oe == 4'h0, "R1 io_oe", io_oe, 0);
        chk(busy == 1'b0 && rd_valid == 1'b0, "R1 busy/valid", {busy, rd_valid}, 0);
        chk(cont_active == 1'b0, "R1 cont", cont_active, 0);

        for (int ai = 0; ai < 3; ai++) begin
            for (int len = 1; len <= 6; len++) begin
                for (int kp = 0; kp < 2; kp++) begin
                    logic [23:0] a;
                    a = (ai == 0) ? 24'h000000 : (ai == 1) ? 24'hFFFFFE : 24'h5A3C81;
                    do_read(a, len, kp[0], len == 3 && kp == 1);
                end
            end
        end

        do_read(24'h00ABCD, 2, 1'b1, 1'b0);
        do_mrst(1'b0);
        do_read(24'h00ABCD, 2, 1'b0, 1'b0);
        do_read(24'h7F0010, 4, 1'b1, 1'b0);
        do_read(24'h7F0020, 4, 1'b1, 1'b0);
        do_mrst(1'b1);
        do_read(24'h000400, 1, 1'b0, 1'b0);

        chk(r11_viol == 0, "R11 clock shape", r11_viol, 0);

        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        vectors++;
        miscompares++;
        $display("FAIL watchdog actual=%0h expected=%0h", 1, 0);
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end

endmodule